// File: doc/BRIEF.md
# ALU Status Flag and Compare Unit

This block runs alongside a 32-bit arithmetic/logic unit that supports fourteen operations. It takes the two operands, the 4-bit operation select and the result the ALU produced for them. From these it derives three status flags: a zero flag, a negative flag and an overflow flag. It also produces a three-way signed comparison of the two operands. The unit is purely combinational, so every output follows its inputs within the same cycle.

Overflow depends on the selected operation. Each arithmetic code has its own test, and the bitwise and logical codes never report overflow. The comparison looks only at the two operands. It is the same whatever operation is selected and whatever result value is supplied, so downstream branch logic can use it without issuing a subtract. Operands are two's-complement signed values for both overflow and comparison. Select encoding: 0 add (a+b), 1 subtract (a-b), 2 reverse subtract (b-a), 3 multiply, 4 divide (a/b), 5 remainder (b%a), 6 to 10 bitwise, 11 to 13 logical. The unused codes 14 and 15 behave as add.

Top module: `alu_status_flags`

## Requirements
- R1: `flag_zero` is 1 exactly when all 32 bits of `alu_result` are 0.
- R2: `flag_neg` equals bit 31 of `alu_result`.
- R3: Exactly one of `cmp_lt`, `cmp_gt`, `cmp_eq` is 1, by signed comparison: `cmp_lt` when a<b, `cmp_gt` when a>b, `cmp_eq` when a==b.
- R4: For select 0 and for the unused selects 14 and 15, `flag_ovf` is 1 when the signed sum a+b does not fit in 32 bits. Otherwise it is 0.
- R5: For select 1, `flag_ovf` is 1 when the signed difference a-b does not fit in 32 bits.
- R6: For select 2, `flag_ovf` is 1 when the signed difference b-a does not fit in 32 bits.
- R7: For select 3, `flag_ovf` is 1 when the full signed product a*b does not fit in 32 bits.
- R8: For select 4, `flag_ovf` is 1 when b is 0 or when a is the most negative value and b is -1. Otherwise it is 0.
- R9: For select 5, `flag_ovf` is 1 when a is 0. Otherwise it is 0, including the case b = most negative value and a = -1.
- R10: For selects 6 to 13, `flag_ovf` is 0 for every operand value.
- R11: The compare outputs do not depend on `op_sel` or `alu_result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand (signed) |
| op_b | input | 32 | Second operand (signed) |
| op_sel | input | 4 | Operation select presented to the ALU |
| alu_result | input | 32 | Result produced by the ALU for this select |
| flag_zero | output | 1 | Result is all zeros |
| flag_neg | output | 1 | Result sign bit |
| flag_ovf | output | 1 | Selected operation overflowed the 32-bit bus |
| cmp_lt | output | 1 | a less than b (signed) |
| cmp_gt | output | 1 | a greater than b (signed) |
| cmp_eq | output | 1 | a equal to b |

## Verification
Add, subtract and reverse subtract are each driven at the extremes: the most positive and most negative values against small operands and against each other. These vectors separate a correct sign-based overflow rule from one that swaps operands or uses the unsigned carry. Multiply is tried with products that just overflow and with products that just fit, which separates a full-width check from a check on the top bits only. Divide is tried with a zero divisor and with the most negative value divided by -1, and remainder with a zero `a`; these expose missing special cases. Equal, ordered and sign-straddling operand pairs under changing selects show that the comparison is signed and independent of the operation. Random vectors then cover the remaining combinations.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned SEL_W  = 4;

  typedef enum logic [SEL_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_RSUB = 4'd2,
    OP_MUL  = 4'd3,
    OP_DIV  = 4'd4,
    OP_REM  = 4'd5,
    OP_BNOT = 4'd6,
    OP_BAND = 4'd7,
    OP_BOR  = 4'd8,
    OP_BXOR = 4'd9,
    OP_BXNR = 4'd10,
    OP_LNOT = 4'd11,
    OP_LAND = 4'd12,
    OP_LOR  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;
endpackage

// File: rtl/flag_result_stat.sv
module flag_result_stat #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] res_i,
  output logic         zero_o,
  output logic         neg_o
);
  always_comb begin
    zero_o = ~|res_i;
    neg_o  = res_i[W-1];
  end
endmodule

// File: rtl/flag_overflow_detect.sv
module flag_overflow_detect
  import alu_flag_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  input  logic         res_msb_i,
  output logic         ovf_o
);
  localparam logic [W-1:0] MOST_NEG  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MINUS_ONE = {W{1'b1}};

  logic signed [W-1:0]   sa, sb;
  logic signed [2*W-1:0] prod;
  logic                  mul_ovf, div_ovf, rem_ovf;
  logic                  add_ovf, sub_ovf, rsub_ovf;

  always_comb begin
    sa   = $signed(a_i);
    sb   = $signed(b_i);
    prod = sa * sb;
    add_ovf  = (a_i[W-1] == b_i[W-1]) && (res_msb_i != a_i[W-1]);
    sub_ovf  = (a_i[W-1] != b_i[W-1]) && (res_msb_i != a_i[W-1]);
    rsub_ovf = (a_i[W-1] != b_i[W-1]) && (res_msb_i != b_i[W-1]);
    mul_ovf  = prod[2*W-1:W] != {W{prod[W-1]}};
    div_ovf  = (b_i == '0) || ((a_i == MOST_NEG) && (b_i == MINUS_ONE));
    rem_ovf  = (a_i == '0);
  end

  always_comb begin
    case (op_i)
      OP_SUB:  ovf_o = sub_ovf;
      OP_RSUB: ovf_o = rsub_ovf;
      OP_MUL:  ovf_o = mul_ovf;
      OP_DIV:  ovf_o = div_ovf;
      OP_REM:  ovf_o = rem_ovf;
      OP_BNOT, OP_BAND, OP_BOR, OP_BXOR, OP_BXNR,
      OP_LNOT, OP_LAND, OP_LOR: ovf_o = 1'b0;
      default: ovf_o = add_ovf;
    endcase
  end

  always_comb begin
    if ((op_i >= OP_BNOT) && (op_i <= OP_LOR))
      AST_LOGIC_NO_OVF: assert (!ovf_o); // R10
  end

  always_comb begin
    if ((op_i == OP_DIV) && (b_i == '0))
      AST_DIV_ZERO_OVF: assert (ovf_o); // R8
  end
endmodule

// File: rtl/flag_signed_compare.sv
module flag_signed_compare #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         lt_o,
  output logic         gt_o,
  output logic         eq_o
);
  always_comb begin
    eq_o = (a_i == b_i);
    lt_o = ($signed(a_i) < $signed(b_i));
    gt_o = ($signed(a_i) > $signed(b_i));
  end
endmodule

// File: rtl/alu_status_flags.sv
module alu_status_flags
  import alu_flag_pkg::*;
(
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [SEL_W-1:0]  op_sel,
  input  logic [DATA_W-1:0] alu_result,
  output logic              flag_zero,
  output logic              flag_neg,
  output logic              flag_ovf,
  output logic              cmp_lt,
  output logic              cmp_gt,
  output logic              cmp_eq
);
  alu_op_e op;
  assign op = alu_op_e'(op_sel);

  flag_result_stat #(.W(DATA_W)) u_stat (
    .res_i  (alu_result),
    .zero_o (flag_zero),
    .neg_o  (flag_neg)
  );

  flag_overflow_detect #(.W(DATA_W)) u_ovf (
    .a_i       (op_a),
    .b_i       (op_b),
    .op_i      (op),
    .res_msb_i (alu_result[DATA_W-1]),
    .ovf_o     (flag_ovf)
  );

  flag_signed_compare #(.W(DATA_W)) u_cmp (
    .a_i  (op_a),
    .b_i  (op_b),
    .lt_o (cmp_lt),
    .gt_o (cmp_gt),
    .eq_o (cmp_eq)
  );

  always_comb begin
    AST_CMP_ONE_HOT: assert ($onehot({cmp_lt, cmp_gt, cmp_eq})); // R3
  end

  always_comb begin
    if (flag_zero)
      AST_ZERO_NOT_NEG: assert (!flag_neg); // R1
  end
endmodule

// File: tb/alu_status_flags_test.sv
module alu_status_flags_test;
  localparam logic [31:0] MNEG = 32'h8000_0000;
  localparam logic [31:0] MPOS = 32'h7FFF_FFFF;

  typedef struct {
    logic [31:0] a, b, res;
    logic [3:0]  sel;
    logic        z, n, o, lt, gt, eq;
    string       tag;
  } item_t;

  logic clk, rst_n;
  logic [31:0] op_a, op_b, alu_result;
  logic [3:0]  op_sel;
  logic flag_zero, flag_neg, flag_ovf, cmp_lt, cmp_gt, cmp_eq;

  item_t sb_q[$];
  int compared, mismatched;
  bit done;

  alu_status_flags uut (
    .op_a(op_a), .op_b(op_b), .op_sel(op_sel), .alu_result(alu_result),
    .flag_zero(flag_zero), .flag_neg(flag_neg), .flag_ovf(flag_ovf),
    .cmp_lt(cmp_lt), .cmp_gt(cmp_gt), .cmp_eq(cmp_eq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic item_t model(logic [31:0] a, logic [31:0] b, logic [3:0] s, string tag);
    item_t it;
    longint sa, sb, t;
    logic [31:0] r;
    bit ov;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ov = 1'b0;
    t  = 0;
    r  = '0;
    case (s)
      4'd1: t = sa - sb;
      4'd2: t = sb - sa;
      4'd3: t = sa * sb;
      4'd4: if (b == 0) ov = 1'b1; else t = sa / sb;
      4'd5: if (a == 0) ov = 1'b1; else t = sb % sa;
      4'd6:  r = ~a;
      4'd7:  r = a & b;
      4'd8:  r = a | b;
      4'd9:  r = a ^ b;
      4'd10: r = a ^~ b;
      4'd11: r = {31'b0, !(|a)};
      4'd12: r = {31'b0, (|a) && (|b)};
      4'd13: r = {31'b0, (|a) || (|b)};
      default: t = sa + sb;
    endcase
    if (s <= 4'd5 || s >= 4'd14) begin
      r = t[31:0];
      if (t != longint'($signed(r))) ov = 1'b1;
    end
    it.a = a; it.b = b; it.sel = s; it.res = r; it.tag = tag;
    it.z = (r == 0); it.n = r[31]; it.o = ov;
    it.lt = sa < sb; it.gt = sa > sb; it.eq = sa == sb;
    return it;
  endfunction

  task automatic drive(logic [31:0] a, logic [31:0] b, logic [3:0] s, string tag);
    item_t it;
    it = model(a, b, s, tag);
    @(posedge clk);
    #1;
    op_a = a; op_b = b; op_sel = s; alu_result = it.res;
    sb_q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      item_t e;
      e = sb_q.pop_front();
      compared++;
      if ({flag_zero, flag_neg, flag_ovf, cmp_lt, cmp_gt, cmp_eq} !==
          {e.z, e.n, e.o, e.lt, e.gt, e.eq}) begin
        mismatched++;
        $display("FAIL %s sel=%0d a=%h b=%h: zno/lt-gt-eq actual %b%b%b/%b%b%b expected %b%b%b/%b%b%b",
                 e.tag, e.sel, e.a, e.b, flag_zero, flag_neg, flag_ovf, cmp_lt, cmp_gt, cmp_eq,
                 e.z, e.n, e.o, e.lt, e.gt, e.eq);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    compared = 0; mismatched = 0; done = 1'b0;
    op_a = '0; op_b = '0; op_sel = '0; alu_result = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: all-zero inputs give zero and equal (R1, R3)
    drive(32'd0, 32'd0, 4'd0, "R1");
    drive(32'd5, -32'sd5, 4'd0, "R1");
    drive(32'd0, 32'd1, 4'd1, "R2");
    drive(MPOS, 32'd1, 4'd0, "R4");
    drive(MNEG, MNEG, 4'd0, "R4");
    drive(MPOS, MNEG, 4'd0, "R4");
    drive(MPOS, MPOS, 4'd14, "R4");
    drive(MNEG, 32'hFFFF_FFFF, 4'd15, "R4");
    drive(MNEG, 32'd1, 4'd1, "R5");
    drive(32'd0, MNEG, 4'd1, "R5");
    drive(32'hFFFF_FFFF, MNEG, 4'd1, "R5");
    drive(32'd1, MNEG, 4'd2, "R6");
    drive(MNEG, 32'd0, 4'd2, "R6");
    drive(MNEG, 32'd1, 4'd2, "R6");
    drive(32'h0001_0000, 32'h0001_0000, 4'd3, "R7");
    drive(32'hFFFF_FFFF, MNEG, 4'd3, "R7");
    drive(MNEG, 32'd1, 4'd3, "R7");
    drive(32'h0000_FFFF, 32'h0000_8001, 4'd3, "R7");
    drive(MNEG, 32'hFFFF_FFFF, 4'd4, "R8");
    drive(32'd77, 32'd0, 4'd4, "R8");
    drive(-32'sd7, 32'd2, 4'd4, "R8");
    drive(32'd0, 32'd9, 4'd5, "R9");
    drive(32'hFFFF_FFFF, MNEG, 4'd5, "R9");
    drive(32'd3, 32'd74, 4'd5, "R9");
    for (int s = 6; s <= 13; s++) begin
      drive(MNEG, MPOS, 4'(s), "R10");
      drive(32'd0, 32'd0, 4'(s), "R10");
    end
    for (int s = 0; s < 16; s++) begin
      drive(MNEG, MPOS, 4'(s), "R11");
      drive(32'h1234_5678, 32'h1234_5678, 4'(s), "R11");
      drive(32'd1, 32'hFFFF_FFFF, 4'(s), "R3");
    end
    for (int i = 0; i < 300; i++) begin
      drive($urandom, (i % 4 == 0) ? 32'($urandom % 3) : $urandom, 4'($urandom), "R3");
    end
    @(posedge clk);
    while (sb_q.size() > 0) @(posedge clk);
    @(posedge clk);
    finish_run();
  end
endmodule